// File: doc/BRIEF.md
# Steerable Delay-and-Sum Beamformer

This block forms a steered mono beam from eight PCM microphone channels running at 384 kHz. Each channel passes through its own circular delay buffer that can hold back the stream by any whole number of samples from 0 to 31. At 384 kHz one sample is about 2.6 us. The delayed channels are added into one 35-bit sum. A gain stage then shifts the sum arithmetically by a number of steps the user picks, and saturates the result to a signed 32-bit word. The delayed output appears two clock cycles after each sample strobe.

The delay settings (taps) live in two sets. Control writes, one channel at a time, go only into a shadow set. The datapath reads only the active set. A small controller with two states, `SW_OPEN` and `SW_ARMED`, copies the entire shadow set into the active set in one clock edge, at a sample boundary. The datapath therefore never computes a sample with a half-updated steering direction.

The transitions of the controller are:
- `ARM_ON_COMMIT` (from `SW_OPEN` on a commit pulse).
- `ARM_ON_DIR` (from `SW_OPEN` on a direction command).
- `SWAP_ON_STROBE` (from `SW_ARMED` to `SW_OPEN` on a strobe).
- `REARM_ON_STROBE` (stays in `SW_ARMED` when a strobe coincides with a fresh commit or direction command).

Two sets of commands come from push buttons. Clockwise and anticlockwise commands step through six preset steering directions, one for each microphone on a ring of six placed 60 degrees apart. Up and down commands step the gain.

Top module: `dsum_steer`

## Requirements
- R1: After reset, these values hold:
  - `out_vld` and `out_data` are 0.
  - `dir_idx` is 0.
  - `gain_idx` is 3 (unity).
  - The active and shadow tap sets both hold the preset for direction 0.
  - Every delay buffer holds zeros.
- R2: For a channel with active tap d, the contribution is the sample presented d strobes earlier. d = 0 means the sample presented on this strobe. Positions not yet written since reset contribute 0. Channel c occupies `smp_data[32*c+31 : 32*c]`, signed two's complement.
- R3: For each cycle with `smp_vld` high, `out_vld` is high for exactly one cycle, two rising edges later. In that cycle `out_data` carries the 35-bit signed sum of the eight delayed channels after the gain stage. At unity gain the sum saturates to the range 0x80000000 to 0x7FFFFFFF.
- R4: Let g be `gain_idx`, in the range 0 to 7. The sum is shifted left by g-3 when g is at least 3, and arithmetically right (toward minus infinity) by 3-g otherwise. The result is then saturated to signed 32 bits.
- R5: `gain_up` raises `gain_idx` by one and `gain_dn` lowers it by one. The index clamps at 7 and at 0. Both commands in the same cycle, or neither, leave it unchanged.
- R6: A tap write (`tap_wr_en`, channel `tap_wr_ch`, delay `tap_wr_dly`) changes only the shadow set. Outputs keep using the old active set until a swap.
- R7: After a `tap_commit` pulse, the first strobe in a later cycle is computed entirely with the shadow set, and that set becomes the active set. A strobe in the same cycle as the commit still uses the old set.
- R8: While a swap is pending (`SW_ARMED`), tap writes are ignored. A write in the same cycle as the commit pulse is accepted.
- R9: `dir_cw` steps `dir_idx` as 0→1→…→5→0. `dir_ccw` steps it the other way. Both in the same cycle leave it unchanged. `dir_idx` always stays in the range 0 to 5.
- R10: A direction command loads the preset for the new direction into the shadow set and arms a swap, even if a swap is already pending. A tap write in the same cycle is ignored. The preset for direction d is:
  - Ring channel c < 6: delay 4·(3−k), where k = min((c−d) mod 6, (d−c) mod 6).
  - Channels 6 and 7: delay 6.
- R11: `out_vld` is low in every cycle that does not fall two edges after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per 384 kHz sample |
| smp_data | input | 256 | Eight signed 32-bit samples, channel c at bits 32c+31:32c |
| tap_wr_en | input | 1 | Write one shadow tap |
| tap_wr_ch | input | 3 | Channel of the tap write |
| tap_wr_dly | input | 5 | Delay in samples, 0 to 31 |
| tap_commit | input | 1 | Shadow set complete; swap at next strobe |
| dir_cw | input | 1 | Rotate steering direction clockwise |
| dir_ccw | input | 1 | Rotate steering direction anticlockwise |
| gain_up | input | 1 | Raise gain by one step |
| gain_dn | input | 1 | Lower gain by one step |
| out_vld | output | 1 | Output sample valid |
| out_data | output | 32 | Gained, saturated mono sample |
| dir_idx | output | 3 | Current steering direction, 0 to 5 |
| gain_idx | output | 3 | Current gain step, 0 to 7 |

## Verification
The swap of the tap set and the sample strobe can fall in the same cycle, either when a commit pulse arrives together with a strobe or when a strobe lands while a swap is armed. The bench drives a commit in the same cycle as a strobe and expects that sample to be built from the old taps, with the next strobe built from the new ones. It also writes a tap while a swap is armed and checks over a later run of strobes that the write never reached the datapath. Direction commands and tap writes are likewise driven in one cycle, and the outputs after the next strobe are compared with the preset alone.

// File: rtl/dsum_pkg.sv
package dsum_pkg;

    // Swap controller states
    typedef enum logic [0:0] {
        SW_OPEN  = 1'b0,   // shadow set accepts tap writes
        SW_ARMED = 1'b1    // shadow set frozen, waiting for a strobe
    } swap_state_e;

    // Shortest distance between two positions on a ring of n slots
    function automatic int ring_dist(input int a, input int b, input int n);
        int fwd;
        int bwd;
        fwd = (a - b + n) % n;
        bwd = (b - a + n) % n;
        return (fwd < bwd) ? fwd : bwd;
    endfunction

endpackage

// File: rtl/dsum_tap_ctrl.sv
module dsum_tap_ctrl
    import dsum_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DLY_W       = 5,
    parameter int NUM_DIR     = 6,
    parameter int PRESET_STEP = 4,
    parameter int CENTER_DLY  = 6,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int DIR_W      = $clog2(NUM_DIR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             tap_wr_en,
    input  logic [CH_W-1:0]  tap_wr_ch,
    input  logic [DLY_W-1:0] tap_wr_dly,
    input  logic             tap_commit,
    input  logic             dir_cw,
    input  logic             dir_ccw,
    output logic [DLY_W-1:0] taps_use [NUM_CH],
    output logic [DIR_W-1:0] dir_idx
);

    localparam int HALF_RING = NUM_DIR / 2;

    // Delay assigned to channel c when steering toward direction d
    function automatic logic [DLY_W-1:0] preset_dly(input int c, input int d);
        if (c >= NUM_DIR) begin
            return DLY_W'(CENTER_DLY);
        end
        return DLY_W'(PRESET_STEP * (HALF_RING - ring_dist(c, d, NUM_DIR)));
    endfunction

    swap_state_e      state_q, state_d;
    logic [DIR_W-1:0] dir_q, dir_nxt;
    logic             dir_cmd;
    logic             swap_now;
    logic [DLY_W-1:0] shadow_q [NUM_CH];
    logic [DLY_W-1:0] active_q [NUM_CH];
    logic [DLY_W-1:0] preset_nxt [NUM_CH];

    // Direction stepping
    assign dir_cmd = dir_cw ^ dir_ccw;

    always_comb begin
        dir_nxt = dir_q;
        if (dir_cw && !dir_ccw) begin
            dir_nxt = (dir_q == DIR_W'(NUM_DIR - 1)) ? '0 : dir_q + DIR_W'(1);
        end else if (dir_ccw && !dir_cw) begin
            dir_nxt = (dir_q == '0) ? DIR_W'(NUM_DIR - 1) : dir_q - DIR_W'(1);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_preset
        assign preset_nxt[c] = preset_dly(c, int'(dir_nxt));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OPEN: begin
                // ARM_ON_COMMIT / ARM_ON_DIR
                if (tap_commit || dir_cmd) begin
                    state_d = SW_ARMED;
                end
            end
            SW_ARMED: begin
                // SWAP_ON_STROBE unless REARM_ON_STROBE
                if (smp_vld && !tap_commit && !dir_cmd) begin
                    state_d = SW_OPEN;
                end
            end
            default: state_d = SW_OPEN;
        endcase
    end

    // Output logic: the strobe that performs the swap already sees the new set
    assign swap_now = (state_q == SW_ARMED) && smp_vld;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            taps_use[c] = swap_now ? shadow_q[c] : active_q[c];
        end
    end

    assign dir_idx = dir_q;

    // Direction, shadow and active sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                shadow_q[c] <= preset_dly(c, 0);
                active_q[c] <= preset_dly(c, 0);
            end
        end else begin
            dir_q <= dir_nxt;
            if (dir_cmd) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    shadow_q[c] <= preset_nxt[c];
                end
            end else if (tap_wr_en && (state_q == SW_OPEN)) begin
                shadow_q[tap_wr_ch] <= tap_wr_dly;
            end
            if (swap_now) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    active_q[c] <= shadow_q[c];
                end
            end
        end
    end

endmodule

// File: rtl/dsum_chan_delay.sv
module dsum_chan_delay #(
    parameter int SAMP_W = 32,
    parameter int DLY_W  = 5,
    localparam int DEPTH = 1 << DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [SAMP_W-1:0] din,
    input  logic [DLY_W-1:0]  dly,
    output logic [SAMP_W-1:0] dout
);

    logic [SAMP_W-1:0] ring_q [DEPTH];
    logic [DLY_W-1:0]  wr_ptr_q;
    logic [DLY_W-1:0]  rd_ptr;

    // Newest stored sample sits at wr_ptr_q - 1
    assign rd_ptr = wr_ptr_q - dly;
    assign dout   = (dly == '0) ? din : ring_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ring_q[i] <= '0;
            end
        end else if (smp_vld) begin
            ring_q[wr_ptr_q] <= din;
            wr_ptr_q         <= wr_ptr_q + DLY_W'(1);
        end
    end

endmodule

// File: rtl/dsum_mix_gain.sv
module dsum_mix_gain #(
    parameter int NUM_CH     = 8,
    parameter int SAMP_W     = 32,
    parameter int GAIN_STEPS = 8,
    parameter int GAIN_UNITY = 3,
    localparam int GAIN_W    = $clog2(GAIN_STEPS),
    localparam int ACC_W     = SAMP_W + $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [SAMP_W-1:0] ch_in [NUM_CH],
    input  logic              gain_up,
    input  logic              gain_dn,
    output logic              out_vld,
    output logic [SAMP_W-1:0] out_data,
    output logic [GAIN_W-1:0] gain_idx
);

    localparam int SHL_MAX = GAIN_STEPS - 1 - GAIN_UNITY;
    localparam int WIDE_W  = ACC_W + SHL_MAX;
    localparam logic [GAIN_W-1:0] G_UNITY = GAIN_W'(GAIN_UNITY);
    localparam logic [GAIN_W-1:0] G_MAX   = GAIN_W'(GAIN_STEPS - 1);
    localparam logic signed [WIDE_W-1:0] SAT_HI =
        {{(WIDE_W - SAMP_W + 1){1'b0}}, {(SAMP_W - 1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] SAT_LO =
        {{(WIDE_W - SAMP_W + 1){1'b1}}, {(SAMP_W - 1){1'b0}}};

    logic [ACC_W-1:0]         acc;
    logic [ACC_W-1:0]         sum_q;
    logic                     sum_vld_q;
    logic [GAIN_W-1:0]        gain_q;
    logic signed [WIDE_W-1:0] wide_in;
    logic signed [WIDE_W-1:0] wide_sh;
    logic [SAMP_W-1:0]        sat_val;

    // Stage 1: sign-extended sum of all delayed channels
    always_comb begin
        acc = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            acc = acc + {{(ACC_W - SAMP_W){ch_in[c][SAMP_W-1]}}, ch_in[c]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= '0;
            sum_vld_q <= 1'b0;
        end else begin
            sum_vld_q <= smp_vld;
            if (smp_vld) begin
                sum_q <= acc;
            end
        end
    end

    // Gain step register with clamping at both ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= G_UNITY;
        end else if (gain_up && !gain_dn && (gain_q != G_MAX)) begin
            gain_q <= gain_q + GAIN_W'(1);
        end else if (gain_dn && !gain_up && (gain_q != '0)) begin
            gain_q <= gain_q - GAIN_W'(1);
        end
    end

    assign gain_idx = gain_q;

    // Stage 2: arithmetic shift then saturation
    always_comb begin
        wide_in = $signed({{SHL_MAX{sum_q[ACC_W-1]}}, sum_q});
        if (gain_q >= G_UNITY) begin
            wide_sh = wide_in <<< (gain_q - G_UNITY);
        end else begin
            wide_sh = wide_in >>> (G_UNITY - gain_q);
        end
        if (wide_sh > SAT_HI) begin
            sat_val = SAT_HI[SAMP_W-1:0];
        end else if (wide_sh < SAT_LO) begin
            sat_val = SAT_LO[SAMP_W-1:0];
        end else begin
            sat_val = wide_sh[SAMP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= sum_vld_q;
            if (sum_vld_q) begin
                out_data <= sat_val;
            end
        end
    end

endmodule

// File: rtl/dsum_steer.sv
module dsum_steer #(
    parameter int NUM_CH      = 8,
    parameter int SAMP_W      = 32,
    parameter int DLY_W       = 5,
    parameter int NUM_DIR     = 6,
    parameter int PRESET_STEP = 4,
    parameter int CENTER_DLY  = 6,
    parameter int GAIN_STEPS  = 8,
    parameter int GAIN_UNITY  = 3,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int DIR_W      = $clog2(NUM_DIR),
    localparam int GAIN_W     = $clog2(GAIN_STEPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic [NUM_CH*SAMP_W-1:0] smp_data,
    input  logic                     tap_wr_en,
    input  logic [CH_W-1:0]          tap_wr_ch,
    input  logic [DLY_W-1:0]         tap_wr_dly,
    input  logic                     tap_commit,
    input  logic                     dir_cw,
    input  logic                     dir_ccw,
    input  logic                     gain_up,
    input  logic                     gain_dn,
    output logic                     out_vld,
    output logic [SAMP_W-1:0]        out_data,
    output logic [DIR_W-1:0]         dir_idx,
    output logic [GAIN_W-1:0]        gain_idx
);

    logic [DLY_W-1:0]  taps_use [NUM_CH];
    logic [SAMP_W-1:0] chan_in  [NUM_CH];
    logic [SAMP_W-1:0] chan_dly [NUM_CH];

    dsum_tap_ctrl #(
        .NUM_CH      (NUM_CH),
        .DLY_W       (DLY_W),
        .NUM_DIR     (NUM_DIR),
        .PRESET_STEP (PRESET_STEP),
        .CENTER_DLY  (CENTER_DLY)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .tap_wr_en  (tap_wr_en),
        .tap_wr_ch  (tap_wr_ch),
        .tap_wr_dly (tap_wr_dly),
        .tap_commit (tap_commit),
        .dir_cw     (dir_cw),
        .dir_ccw    (dir_ccw),
        .taps_use   (taps_use),
        .dir_idx    (dir_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign chan_in[c] = smp_data[c*SAMP_W +: SAMP_W];

        dsum_chan_delay #(
            .SAMP_W (SAMP_W),
            .DLY_W  (DLY_W)
        ) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (smp_vld),
            .din     (chan_in[c]),
            .dly     (taps_use[c]),
            .dout    (chan_dly[c])
        );
    end

    dsum_mix_gain #(
        .NUM_CH     (NUM_CH),
        .SAMP_W     (SAMP_W),
        .GAIN_STEPS (GAIN_STEPS),
        .GAIN_UNITY (GAIN_UNITY)
    ) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .ch_in    (chan_dly),
        .gain_up  (gain_up),
        .gain_dn  (gain_dn),
        .out_vld  (out_vld),
        .out_data (out_data),
        .gain_idx (gain_idx)
    );

endmodule

// File: rtl/dsum_steer_chk.sv
module dsum_steer_chk #(
    parameter int DIR_W      = 3,
    parameter int NUM_DIR    = 6,
    parameter int GAIN_W     = 3,
    parameter int GAIN_STEPS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic              dir_cw,
    input logic              dir_ccw,
    input logic              gain_up,
    input logic              gain_dn,
    input logic              out_vld,
    input logic [DIR_W-1:0]  dir_idx,
    input logic [GAIN_W-1:0] gain_idx
);

    localparam logic [DIR_W-1:0]  D_LAST = DIR_W'(NUM_DIR - 1);
    localparam logic [GAIN_W-1:0] G_MAX  = GAIN_W'(GAIN_STEPS - 1);

    AST_VLD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(smp_vld, 2)); // R11

    AST_STROBE_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_vld, 2) && $past(rst_n, 2) && $past(rst_n)) |-> out_vld); // R3

    AST_GAIN_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_up && !gain_dn && gain_idx != G_MAX) |=>
        gain_idx == $past(gain_idx) + GAIN_W'(1)); // R5

    AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_up && !gain_dn && gain_idx == G_MAX) |=> gain_idx == G_MAX); // R5

    AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_dn && !gain_up && gain_idx == '0) |=> gain_idx == '0); // R5

    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_up == gain_dn) |=> $stable(gain_idx)); // R5

    AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dir_idx <= D_LAST); // R9

    AST_DIR_CW: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_cw && !dir_ccw) |=>
        dir_idx == (($past(dir_idx) == D_LAST) ? '0 : $past(dir_idx) + DIR_W'(1))); // R9

    AST_DIR_CCW: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_ccw && !dir_cw) |=>
        dir_idx == (($past(dir_idx) == '0) ? D_LAST : $past(dir_idx) - DIR_W'(1))); // R9

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_cw == dir_ccw) |=> $stable(dir_idx)); // R9

endmodule

bind dsum_steer dsum_steer_chk #(
    .DIR_W      (DIR_W),
    .NUM_DIR    (NUM_DIR),
    .GAIN_W     (GAIN_W),
    .GAIN_STEPS (GAIN_STEPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .dir_cw   (dir_cw),
    .dir_ccw  (dir_ccw),
    .gain_up  (gain_up),
    .gain_dn  (gain_dn),
    .out_vld  (out_vld),
    .dir_idx  (dir_idx),
    .gain_idx (gain_idx)
);

// File: tb/dsum_steer_tb_top.sv
module dsum_steer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 8;
    localparam int SW    = 32;
    localparam int DW    = 5;
    localparam int HDEP  = 32;

    // Table walk: all channels carry v, zero taps, unity gain -> {v, expected}
    localparam logic [63:0] TBL [8] = '{
        {32'h0000_0001, 32'h0000_0008},
        {32'hFFFF_FFFF, 32'hFFFF_FFF8},
        {32'h0000_0064, 32'h0000_0320},
        {32'h0FFF_FFFF, 32'h7FFF_FFF8},
        {32'h1000_0000, 32'h7FFF_FFFF},
        {32'h7FFF_FFFF, 32'h7FFF_FFFF},
        {32'hF000_0000, 32'h8000_0000},
        {32'h8000_0000, 32'h8000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic              tap_wr_en = 1'b0;
    logic [2:0]        tap_wr_ch = '0;
    logic [DW-1:0]     tap_wr_dly = '0;
    logic              tap_commit = 1'b0;
    logic              dir_cw = 1'b0;
    logic              dir_ccw = 1'b0;
    logic              gain_up = 1'b0;
    logic              gain_dn = 1'b0;
    logic              out_vld;
    logic [SW-1:0]     out_data;
    logic [2:0]        dir_idx;
    logic [2:0]        gain_idx;

    int n_tests = 0;
    int n_fail  = 0;
    logic [SW-1:0] hist [NCH][HDEP];
    int            mdl_taps [NCH];
    int            mdl_gain;
    logic [31:0]   lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsum_steer dut_i (
        .clk (clk), .rst_n (rst_n), .smp_vld (smp_vld), .smp_data (smp_data),
        .tap_wr_en (tap_wr_en), .tap_wr_ch (tap_wr_ch), .tap_wr_dly (tap_wr_dly),
        .tap_commit (tap_commit), .dir_cw (dir_cw), .dir_ccw (dir_ccw),
        .gain_up (gain_up), .gain_dn (gain_dn), .out_vld (out_vld),
        .out_data (out_data), .dir_idx (dir_idx), .gain_idx (gain_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int preset(input int c, input int d);
        int f, b, k;
        if (c >= 6) return 6;
        f = (c - d + 6) % 6;
        b = (d - c + 6) % 6;
        k = (f < b) ? f : b;
        return 4 * (3 - k);
    endfunction

    function automatic logic [31:0] model_exp(input logic [NCH*SW-1:0] d);
        longint acc = 0;
        longint s;
        for (int c = 0; c < NCH; c++) begin
            logic [SW-1:0] v;
            v = (mdl_taps[c] == 0) ? d[c*SW +: SW] : hist[c][mdl_taps[c]-1];
            acc += longint'($signed(v));
        end
        if (mdl_gain >= 3) s = acc <<< (mdl_gain - 3);
        else               s = acc >>> (3 - mdl_gain);
        if (s > 64'sh7FFF_FFFF)       s = 64'sh7FFF_FFFF;
        else if (s < -64'sh8000_0000) s = -64'sh8000_0000;
        return s[31:0];
    endfunction

    function automatic logic [NCH*SW-1:0] gen_data();
        logic [NCH*SW-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            d[c*SW +: SW] = $signed(lcg) >>> 4;
        end
        return d;
    endfunction

    task automatic pulse(input logic cw, input logic ccw, input logic up, input logic dn,
                         input logic cm, input logic wr, input int ch, input int dly);
        @(negedge clk);
        dir_cw = cw; dir_ccw = ccw; gain_up = up; gain_dn = dn;
        tap_commit = cm; tap_wr_en = wr; tap_wr_ch = 3'(ch); tap_wr_dly = DW'(dly);
        @(negedge clk);
        dir_cw = 0; dir_ccw = 0; gain_up = 0; gain_dn = 0;
        tap_commit = 0; tap_wr_en = 0;
    endtask

    // One strobe; returns outputs sampled after the second rising edge
    task automatic strobe(input logic [NCH*SW-1:0] d, input logic cm,
                          output logic gv, output logic [31:0] gd);
        @(negedge clk);
        smp_vld = 1; smp_data = d; tap_commit = cm;
        @(negedge clk);
        smp_vld = 0; tap_commit = 0;
        @(negedge clk);
        gv = out_vld; gd = out_data;
        for (int c = 0; c < NCH; c++) begin
            for (int k = HDEP-1; k > 0; k--) hist[c][k] = hist[c][k-1];
            hist[c][0] = d[c*SW +: SW];
        end
    endtask

    task automatic run_rand(input int n, input string tag);
        logic gv;
        logic [31:0] gd, ex;
        logic [NCH*SW-1:0] d;
        for (int i = 0; i < n; i++) begin
            d  = gen_data();
            ex = model_exp(d);
            strobe(d, 1'b0, gv, gd);
            chk({tag, " vld"}, {31'd0, gv}, 32'd1);
            chk(tag, gd, ex);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic gv;
        logic [31:0] gd, ex;
        logic [NCH*SW-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < HDEP; k++) hist[c][k] = '0;
            mdl_taps[c] = preset(c, 0);
        end
        mdl_gain = 3;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_vld", {31'd0, out_vld}, 32'd0);
        chk("R1 out_data", out_data, 32'd0);
        chk("R1 dir_idx", {29'd0, dir_idx}, 32'd0);
        chk("R1 gain_idx", {29'd0, gain_idx}, 32'd3);

        // R1 R2 R10: direction-0 preset active from reset, zero history
        run_rand(20, "R2 preset0 delays");

        // R6: shadow writes do not disturb the active set
        for (int c = 0; c < NCH; c++) pulse(0, 0, 0, 0, 0, 1, c, 0);
        run_rand(2, "R6 shadow only");

        // R7: commit together with a strobe -> that strobe still uses old taps
        d = gen_data(); ex = model_exp(d);
        strobe(d, 1'b1, gv, gd);
        chk("R7 same-cycle old taps", gd, ex);
        for (int c = 0; c < NCH; c++) mdl_taps[c] = 0;

        // R3: table walk with zero taps, unity gain, saturation at both ends
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < NCH; c++) d[c*SW +: SW] = TBL[i][63:32];
            strobe(d, 1'b0, gv, gd);
            chk(i == 0 ? "R7 first strobe new taps" : "R3 table sum", gd, TBL[i][31:0]);
        end

        // R8: write in commit cycle accepted, write while armed ignored
        pulse(0, 0, 0, 0, 1, 1, 0, 5);
        pulse(0, 0, 0, 0, 0, 1, 1, 9);
        mdl_taps[0] = 5;
        run_rand(14, "R8 armed write ignored");
        pulse(0, 0, 0, 0, 1, 0, 0, 0);
        run_rand(12, "R8 shadow untouched");

        // R4 R5: gain clamps and shifts
        for (int i = 0; i < 6; i++) pulse(0, 0, 1, 0, 0, 0, 0, 0);
        chk("R5 gain ceiling", {29'd0, gain_idx}, 32'd7);
        mdl_gain = 7;
        run_rand(4, "R4 left shift");
        pulse(0, 0, 1, 1, 0, 0, 0, 0);
        chk("R5 both gain cmds", {29'd0, gain_idx}, 32'd7);
        for (int i = 0; i < 10; i++) pulse(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 gain floor", {29'd0, gain_idx}, 32'd0);
        mdl_gain = 0;
        run_rand(4, "R4 right shift");
        for (int i = 0; i < 3; i++) pulse(0, 0, 1, 0, 0, 0, 0, 0);
        chk("R5 gain back to unity", {29'd0, gain_idx}, 32'd3);
        mdl_gain = 3;

        // R9 R10: direction rotation loads presets atomically
        pulse(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 cw step", {29'd0, dir_idx}, 32'd1);
        for (int c = 0; c < NCH; c++) mdl_taps[c] = preset(c, 1);
        run_rand(14, "R10 preset dir1");
        pulse(0, 1, 0, 0, 0, 0, 0, 0);
        pulse(0, 1, 0, 0, 0, 0, 0, 0);
        chk("R9 ccw wrap", {29'd0, dir_idx}, 32'd5);
        for (int c = 0; c < NCH; c++) mdl_taps[c] = preset(c, 5);
        run_rand(14, "R10 preset dir5");
        pulse(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 cw wrap", {29'd0, dir_idx}, 32'd0);
        pulse(1, 1, 0, 0, 0, 0, 0, 0);
        chk("R9 both dir cmds", {29'd0, dir_idx}, 32'd0);
        pulse(1, 0, 0, 0, 0, 1, 3, 20);
        chk("R9 cw again", {29'd0, dir_idx}, 32'd1);
        for (int c = 0; c < NCH; c++) mdl_taps[c] = preset(c, 1);
        run_rand(14, "R10 write with dir ignored");

        // R11: no valid without a strobe
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 idle no vld", {31'd0, out_vld}, 32'd0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule